// File: doc/BRIEF.md
# Stop-Mode Wake-Up Controller

This block runs the deepest sleep state of a small microcontroller core. When the core issues a stop command, the block halts the core and turns off the enable of the main oscillator and the enable of the secondary (slow) oscillator in the same cycle. The block leaves the stop state only when one of eight external pins falls from high to low and software has allowed that pin as a wake source. The eight pins are grouped as two 4-bit ports.

Software writes an 8-bit wake mask before it issues the stop command. The mask cannot be read back. Each pin passes through a two-flop synchronizer before its edge is examined. When an enabled pin falls, the block first turns the oscillator enables back on. It then holds the core for a fixed settling interval. After that interval it releases the core and raises a one-cycle wake pulse, and the core goes on with the instruction that follows its stop command.

Top module: `wk_stop_ctrl`

## Requirements
- R1: After reset the wake mask is all zeros and the block is running: `main_osc_en` is 1, `sub_osc_en` equals `dual_slow`, and `core_halt` and `wake_pulse` are 0.
- R2: Mask bit i (i = 0..3) enables `port_a[i]` as a wake source. Mask bit 4+i enables `port_b[i]`. A write with `mask_we` high takes effect from the next clock edge.
- R3: While stopped, a high-to-low transition on an enabled pin ends stop mode. `main_osc_en` is 1 three clock edges after the first edge that samples the pin low.
- R4: While stopped, rising edges on any pin and falling edges on pins whose mask bit is 0 leave `core_halt` at 1 and both oscillator enables at 0.
- R5: A `stop_req` sampled high while running makes `core_halt` 1 and `main_osc_en` 0 from the next clock edge.
- R6: While running, `sub_osc_en` follows `dual_slow`. While stopped, `sub_osc_en` is 0 in both clock modes.
- R7: After a wake event the oscillator enables stay on with `core_halt` still 1 for RESTART_CYCLES edges. Then `core_halt` drops to 0 and `wake_pulse` is 1 for exactly that first running cycle.
- R8: With an all-zero mask, no pin activity ends stop mode.
- R9: A `stop_req` that arrives during the stop or settling states is ignored.
- R10: Pin edges while running produce no wake pulse and do not halt the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_we | input | 1 | Write strobe for the wake mask |
| mask_wdata | input | 8 | New wake mask value |
| stop_req | input | 1 | Stop command from the core |
| dual_slow | input | 1 | Dual-clock slow mode select |
| port_a | input | 4 | First external pin group |
| port_b | input | 4 | Second external pin group |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Secondary oscillator enable |
| core_halt | output | 1 | Holds the core while stopped or settling |
| wake_pulse | output | 1 | One-cycle resume indication |

## Verification
A corrupted mask bit shows up within four edges of the next falling edge on the affected pin. Either an enabled pin fails to bring `main_osc_en` back, or a disabled pin wakes the core. A wrong settling count moves the `core_halt` release and the `wake_pulse` by at least one cycle. A state register stuck in stop or in running shows up on `core_halt` one edge after the next `stop_req` or wake edge. The reference model compares all four outputs on every clock, so any of these faults is reported in the cycle where it first reaches the ports.

// File: rtl/wk_pkg.sv
package wk_pkg;
   typedef enum logic [1:0] {
      WK_RUN     = 2'd0,
      WK_STOP    = 2'd1,
      WK_SETTLE  = 2'd2
   } wk_state_e;
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
   parameter int W       = 8,
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("wk_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("wk_sync: W must be positive");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL}};
         else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/wk_fall_det.sv
module wk_fall_det #(
   parameter int W       = 8,
   parameter bit REG_HIT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] level,
   input  logic [W-1:0] enable,
   input  logic         arm,
   output logic         hit
);
   logic [W-1:0] prev_q;
   logic         hit_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '1;
      else        prev_q <= level;
   end

   assign hit_now = arm & (|(prev_q & ~level & enable));

   if (REG_HIT) begin : g_reg
      logic hit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hit_q <= 1'b0;
         else        hit_q <= hit_now & arm;
      end
      assign hit = hit_q & arm;
   end else begin : g_comb
      assign hit = hit_now;
   end
endmodule

// File: rtl/wk_ctrl.sv
module wk_ctrl
   import wk_pkg::*;
#(
   parameter int RESTART_CYCLES = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      stop_req,
   input  logic      hit,
   output wk_state_e state,
   output logic      wake_pulse
);
   localparam int CNT_W = (RESTART_CYCLES > 1) ? $clog2(RESTART_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RESTART_CYCLES - 1);

   if (RESTART_CYCLES < 1) begin : g_bad_restart
      $error("wk_ctrl: RESTART_CYCLES must be at least 1");
   end

   wk_state_e        state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             wake_q, wake_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      wake_d  = 1'b0;
      unique case (state_q)
         WK_RUN: begin
            if (stop_req) state_d = WK_STOP;
         end
         WK_STOP: begin
            if (hit) begin
               state_d = WK_SETTLE;
               cnt_d   = '0;
            end
         end
         WK_SETTLE: begin
            if (cnt_q == CNT_LAST) begin
               state_d = WK_RUN;
               wake_d  = 1'b1;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: state_d = WK_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WK_RUN;
         cnt_q   <= '0;
         wake_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         wake_q  <= wake_d;
      end
   end

   assign state      = state_q;
   assign wake_pulse = wake_q;
endmodule

// File: rtl/wk_stop_ctrl.sv
module wk_stop_ctrl
   import wk_pkg::*;
#(
   parameter int PORT_W         = 4,
   parameter int SYNC_STAGES    = 2,
   parameter int RESTART_CYCLES = 4,
   parameter bit REG_HIT        = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  mask_we,
   input  logic [2*PORT_W-1:0]   mask_wdata,
   input  logic                  stop_req,
   input  logic                  dual_slow,
   input  logic [PORT_W-1:0]     port_a,
   input  logic [PORT_W-1:0]     port_b,
   output logic                  main_osc_en,
   output logic                  sub_osc_en,
   output logic                  core_halt,
   output logic                  wake_pulse
);
   localparam int PIN_W = 2 * PORT_W;

   if (PORT_W < 1) begin : g_bad_port
      $error("wk_stop_ctrl: PORT_W must be positive");
   end

   logic [PIN_W-1:0] mask_q;
   logic [PIN_W-1:0] pins_raw, pins_s;
   logic             hit;
   wk_state_e        state;

   assign pins_raw = {port_b, port_a};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_we) mask_q <= mask_wdata;
   end

   wk_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   wk_fall_det #(.W(PIN_W), .REG_HIT(REG_HIT)) u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .level  (pins_s),
      .enable (mask_q),
      .arm    (state == WK_STOP),
      .hit    (hit)
   );

   wk_ctrl #(.RESTART_CYCLES(RESTART_CYCLES)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .stop_req   (stop_req),
      .hit        (hit),
      .state      (state),
      .wake_pulse (wake_pulse)
   );

   assign main_osc_en = (state != WK_STOP);
   assign sub_osc_en  = dual_slow & (state != WK_STOP);
   assign core_halt   = (state != WK_RUN);
endmodule

// File: rtl/wk_stop_chk.sv
module wk_stop_chk #(
   parameter int PIN_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             stop_req,
   input logic             dual_slow,
   input logic [PIN_W-1:0] mask,
   input logic             main_osc_en,
   input logic             sub_osc_en,
   input logic             core_halt,
   input logic             wake_pulse
);
   // R1
   run_osc_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !core_halt |-> main_osc_en);

   // R5
   stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_halt && stop_req) |=> (core_halt && !main_osc_en));

   // R6
   sub_off_in_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !main_osc_en |-> !sub_osc_en);

   // R6
   sub_follows_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !core_halt |-> (sub_osc_en == dual_slow));

   // R7
   wake_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> (!core_halt && $past(core_halt)));

   // R7
   wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);

   // R8
   zero_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0 && !main_osc_en) |=> !main_osc_en);
endmodule

bind wk_stop_ctrl wk_stop_chk #(.PIN_W(PIN_W)) u_stop_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .stop_req    (stop_req),
   .dual_slow   (dual_slow),
   .mask        (mask_q),
   .main_osc_en (main_osc_en),
   .sub_osc_en  (sub_osc_en),
   .core_halt   (core_halt),
   .wake_pulse  (wake_pulse)
);

// File: tb/tb_wk_stop_ctrl.sv
`timescale 1ns/1ps
module tb_wk_stop_ctrl;
   localparam int PW  = 4;
   localparam int RCY = 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          mask_we = 1'b0;
   logic [7:0]    mask_wdata = '0;
   logic          stop_req = 1'b0;
   logic          dual_slow = 1'b1;
   logic [PW-1:0] port_a = '1;
   logic [PW-1:0] port_b = '1;
   logic          main_osc_en, sub_osc_en, core_halt, wake_pulse;

   wk_stop_ctrl #(.PORT_W(PW), .SYNC_STAGES(2), .RESTART_CYCLES(RCY), .REG_HIT(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
      .stop_req(stop_req), .dual_slow(dual_slow), .port_a(port_a), .port_b(port_b),
      .main_osc_en(main_osc_en), .sub_osc_en(sub_osc_en),
      .core_halt(core_halt), .wake_pulse(wake_pulse)
   );

   int total = 0;
   int bad   = 0;
   int wakes = 0;
   bit done  = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference: 0 running, 1 stopped, 2 settling
   int       m_st = 0;
   int       m_cnt = 0;
   bit       m_wake = 0;
   bit [7:0] m_mask = '0;
   bit [7:0] h1 = '1, h2 = '1, h3 = '1;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_wake = 0; m_mask = '0;
         h1 = '1; h2 = '1; h3 = '1;
      end else begin
         bit [7:0] falls;
         bit       nw;
         falls = h3 & ~h2 & m_mask;
         nw = 0;
         if (m_st == 0) begin
            if (stop_req) m_st = 1;
         end else if (m_st == 1) begin
            if (falls != 0) begin m_st = 2; m_cnt = 0; end
         end else begin
            if (m_cnt == RCY - 1) begin m_st = 0; nw = 1; end
            else m_cnt++;
         end
         m_wake = nw;
         if (mask_we) m_mask = mask_wdata;
         h3 = h2; h2 = h1; h1 = {port_b, port_a};
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         check(main_osc_en == (m_st != 1), "R3 main_osc_en vs model", int'(main_osc_en), int'(m_st != 1));
         check(sub_osc_en == (dual_slow && m_st != 1), "R6 sub_osc_en vs model", int'(sub_osc_en), int'(dual_slow && m_st != 1));
         check(core_halt == (m_st != 0), "R5 core_halt vs model", int'(core_halt), int'(m_st != 0));
         check(wake_pulse == m_wake, "R7 wake_pulse vs model", int'(wake_pulse), int'(m_wake));
         if (wake_pulse) wakes++;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; stop_req = 1'b0; mask_we = 1'b0;
      port_a = '1; port_b = '1;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
   endtask

   task automatic write_mask(input logic [7:0] v);
      mask_we = 1'b1; mask_wdata = v;
      cyc(1);
      mask_we = 1'b0;
   endtask

   task automatic enter_stop();
      stop_req = 1'b1;
      cyc(1);
      stop_req = 1'b0;
   endtask

   task automatic set_pin(input int i, input logic v);
      if (i < PW) port_a[i] = v;
      else        port_b[i-PW] = v;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      done = 1'b1;
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int w0;
      do_reset();
      // R1 reset state
      check(main_osc_en == 1'b1, "R1 main_osc_en", int'(main_osc_en), 1);
      check(sub_osc_en == 1'b1, "R1 sub_osc_en", int'(sub_osc_en), 1);
      check(core_halt == 1'b0, "R1 core_halt", int'(core_halt), 0);
      check(wake_pulse == 1'b0, "R1 wake_pulse", int'(wake_pulse), 0);

      // R8 zero mask: nothing wakes
      enter_stop();
      check(core_halt == 1'b1, "R5 halted after stop", int'(core_halt), 1);
      check(sub_osc_en == 1'b0, "R6 sub off in stop", int'(sub_osc_en), 0);
      port_a = '0; port_b = '0; cyc(4);
      port_a = '1; port_b = '1; cyc(4);
      port_a = '0; port_b = '0; cyc(8);
      check(core_halt == 1'b1, "R8 still halted", int'(core_halt), 1);
      check(main_osc_en == 1'b0, "R8 osc still off", int'(main_osc_en), 0);
      do_reset();

      // R10 edges while running, then R4 rise / disabled pins in stop
      write_mask(8'h01);
      w0 = wakes;
      port_a[0] = 1'b0; port_b = '0; cyc(6);
      check(wakes == w0, "R10 no wake while running", wakes, w0);
      check(core_halt == 1'b0, "R10 still running", int'(core_halt), 0);
      port_b = '1; cyc(4);
      enter_stop();
      port_a[0] = 1'b1; cyc(4);
      port_b[0] = 1'b0; port_a[1] = 1'b0; cyc(8);
      check(core_halt == 1'b1, "R4 rise/disabled ignored", int'(core_halt), 1);
      check(main_osc_en == 1'b0, "R4 osc off", int'(main_osc_en), 0);
      port_a[0] = 1'b0;
      cyc(3);
      check(main_osc_en == 1'b1, "R3 osc back on", int'(main_osc_en), 1);
      check(core_halt == 1'b1, "R7 still settling", int'(core_halt), 1);
      cyc(RCY);
      check(core_halt == 1'b0, "R7 released", int'(core_halt), 0);
      check(wake_pulse == 1'b1, "R7 wake pulse", int'(wake_pulse), 1);
      cyc(1);
      check(wake_pulse == 1'b0, "R7 pulse one cycle", int'(wake_pulse), 0);
      port_a = '1; port_b = '1; cyc(4);

      // R2 each pin against its own bit
      for (int i = 0; i < 8; i++) begin
         dual_slow = i[0];
         write_mask(8'(1 << i));
         enter_stop();
         cyc(2);
         check(main_osc_en == 1'b0, "R5 stopped", int'(main_osc_en), 0);
         set_pin(i, 1'b0);
         cyc(3 + RCY);
         check(core_halt == 1'b0, "R2 pin wakes", int'(core_halt), 0);
         check(wake_pulse == 1'b1, "R2 pin wake pulse", int'(wake_pulse), 1);
         set_pin(i, 1'b1);
         cyc(3);
      end

      // R2 mapping: low-port mask does not accept high-port pins
      write_mask(8'h0F);
      enter_stop();
      port_b = '0; cyc(8);
      check(core_halt == 1'b1, "R2 port_b masked", int'(core_halt), 1);
      port_a[2] = 1'b0; cyc(3 + RCY);
      check(core_halt == 1'b0, "R2 port_a[2] wakes", int'(core_halt), 0);
      port_a = '1; port_b = '1; cyc(4);

      // R9 stop request during settling ignored
      enter_stop();
      port_a[3] = 1'b0;
      cyc(4);
      stop_req = 1'b1; cyc(1); stop_req = 1'b0;
      cyc(RCY);
      check(core_halt == 1'b0, "R9 stop during settle ignored", int'(core_halt), 0);
      port_a = '1; cyc(4);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule